// File: doc/BRIEF.md
# Byte-Wide Flash Program and Erase Sequencer

This block sits between a simple host command port and the pins of a byte-wide asynchronous flash device. The host offers one of four operations: write a byte, erase a small sector, erase a larger block, or erase the whole array. The sequencer then produces the unlock and command writes that the flash requires, one bus write at a time. Each write has a setup, strobe and hold phase, and the length of each phase is a parameter counted in clock cycles.

After the final command write the sequencer reads the target location again and again. It watches status bit 6, which flips on every read while the flash is busy. The operation counts as finished once four reads in a row return the same bit 6: the first matching pair, then two further reads that confirm it. This covers the case where the internal operation finishes just as a read is taken. A cycle counter, chosen per operation, places an upper bound on the wait. A one-cycle done pulse closes every command, and it carries an error flag when that bound ran out.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Operation code 0 (byte write) emits exactly four bus writes, in this order: 0xAA at 0x00AAA, 0x55 at 0x00555, 0xA0 at 0x00AAA, then the host data byte at the host address.
- R2: Operation codes 1 (sector), 2 (block) and 3 (whole array) emit exactly six bus writes: 0xAA@0x00AAA, 0x55@0x00555, 0x80@0x00AAA, 0xAA@0x00AAA, 0x55@0x00555. The sixth write is 0x30 at the host address for code 1, 0x50 at the host address for code 2, and 0x10 at 0x00AAA for code 3.
- R3: In every bus write, address and data are driven at least T_SETUP cycles before chip select and write strobe fall. Both strobes then stay low for exactly T_PULSE cycles and rise together. Address and data do not change while the strobes are low, and they stay valid for at least T_HOLD cycles after the rise.
- R4: Output enable stays high for the whole of every bus write, and the data bus is driven only while output enable is high. A status read holds chip select and output enable low for exactly T_RDACC cycles, keeps the write strobe high, and leaves the data bus undriven.
- R5: Every status read uses the address given with the command, for all four operation codes.
- R6: Done is raised without error only after four consecutive status reads return the same bit 6. A read whose bit 6 differs from the read before it restarts the count, so a flash that toggles for B reads is read exactly B+4 times.
- R7: If the reads have not settled within the timeout limit for the operation (TMO_PROG for code 0, TMO_ERASE for codes 1 and 2, TMO_CHIP for code 3), counted from the end of the last write, then done is raised with done_err = 1. This happens once the status read in progress ends.
- R8: cmd_ready is high only while the block is idle, and a command is taken only on a cycle where cmd_valid and cmd_ready are both high. A command offered while busy is not taken and produces no bus writes.
- R9: done is a single-cycle pulse, and done_err is high only together with done.
- R10: After reset, chip select, write strobe and output enable are high, the data bus is undriven, done is low, and cmd_ready is high one cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Block is idle and can take a command |
| cmd_op | input | 2 | 0 byte write, 1 sector erase, 2 block erase, 3 whole-array erase |
| cmd_addr | input | 20 | Target byte, sector or block address |
| cmd_data | input | 8 | Byte to write (used by code 0 only) |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Set with done when the wait limit ran out |
| fl_addr | output | 20 | Flash address bus |
| fl_dq_o | output | 8 | Flash data bus, outgoing value |
| fl_dq_oe | output | 1 | Drive enable for the flash data bus |
| fl_dq_i | input | 8 | Flash data bus, incoming value |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |

## Verification
An error in the step counter or the command table shows up on the first wrong bus write, within one write cycle of the fault, as a wrong address or byte in the write sequence. A fault in the phase counter of the bus engine shows up on the strobes of the very next bus cycle as a wrong pulse length, or as setup or hold time that is too short. A fault in the toggle tracker or the timeout counter shows up only at the done pulse: the number of status reads differs from B+4, done_err has the wrong value, or done comes at the wrong distance from the last write. The bench therefore counts reads exactly and measures that distance.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } flash_op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_word_t;

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = 20'h00AAA;
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = 20'h00555;

  // Index of the final write of a command sequence.
  function automatic logic [STEP_W-1:0] final_step(input flash_op_e op);
    return (op == OP_PROG) ? STEP_W'(3) : STEP_W'(5);
  endfunction

  // Address/data pair of each write in a command sequence.
  function automatic bus_word_t seq_word(input flash_op_e op,
                                         input logic [STEP_W-1:0] step,
                                         input logic [ADDR_W-1:0] tgt,
                                         input logic [DATA_W-1:0] val);
    bus_word_t w;
    case (step)
      STEP_W'(0): w = '{addr: KEY_ADDR_A, data: 8'hAA};
      STEP_W'(1): w = '{addr: KEY_ADDR_B, data: 8'h55};
      STEP_W'(2): w = '{addr: KEY_ADDR_A, data: (op == OP_PROG) ? 8'hA0 : 8'h80};
      STEP_W'(3): w = (op == OP_PROG) ? '{addr: tgt, data: val}
                                      : '{addr: KEY_ADDR_A, data: 8'hAA};
      STEP_W'(4): w = '{addr: KEY_ADDR_B, data: 8'h55};
      default: begin
        case (op)
          OP_SECTOR: w = '{addr: tgt, data: 8'h30};
          OP_BLOCK:  w = '{addr: tgt, data: 8'h50};
          default:   w = '{addr: KEY_ADDR_A, data: 8'h10};
        endcase
      end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fc_bus_cycle.sv
module fc_bus_cycle #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 6,
  parameter int T_HOLD  = 4,
  parameter int T_RDACC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_i,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  localparam int T_A   = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int T_B   = (T_HOLD > T_RDACC) ? T_HOLD : T_RDACC;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      rd_q     <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      fl_addr  <= '0;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_SETUP;
            cnt      <= CNT_W'(T_SETUP - 1);
            rd_q     <= is_read;
            fl_addr  <= addr_in;
            fl_dq_o  <= wdata;
            fl_dq_oe <= !is_read;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase   <= PH_STROBE;
            cnt     <= rd_q ? CNT_W'(T_RDACC - 1) : CNT_W'(T_PULSE - 1);
            fl_ce_n <= 1'b0;
            fl_we_n <= rd_q;
            fl_oe_n <= !rd_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase   <= PH_HOLD;
            cnt     <= CNT_W'(T_HOLD - 1);
            fl_ce_n <= 1'b1;
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            if (rd_q) rdata <= dq_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            phase    <= PH_IDLE;
            fl_dq_oe <= 1'b0;
            done     <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // Checker counter: length of the current low run of the write strobe.
  logic [15:0] we_low_run;
  always_ff @(posedge clk) begin
    if (rst) we_low_run <= '0;
    else if (!fl_we_n) we_low_run <= (we_low_run == 16'hFFFF) ? we_low_run : we_low_run + 1'b1;
    else we_low_run <= '0;
  end

  a_r3_pulse_min: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (we_low_run >= 16'(T_PULSE)));

  a_r3_strobe_stable: assert property (@(posedge clk) disable iff (rst)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

  a_r3_we_needs_ce: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);

  a_r4_drive_oe_high: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_oe_n);

  a_r4_read_we_high: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (fl_we_n && !fl_dq_oe));
endmodule

// File: rtl/fc_toggle_poll.sv
module fc_toggle_poll #(
  parameter int CONFIRM_READS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample,
  input  logic bit_in,
  output logic settled
);
  localparam int NEED = CONFIRM_READS + 1;
  localparam int AW   = $clog2(NEED + 1);

  logic          have_prev;
  logic          prev_bit;
  logic [AW-1:0] agree;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      agree     <= '0;
      settled   <= 1'b0;
    end else if (sample) begin
      have_prev <= 1'b1;
      prev_bit  <= bit_in;
      if (have_prev && (bit_in == prev_bit)) begin
        if (agree == AW'(NEED - 1)) settled <= 1'b1;
        else agree <= agree + 1'b1;
      end else begin
        agree <= '0;
      end
    end
  end

  a_r6_settle_on_read: assert property (@(posedge clk) disable iff (rst)
    $rose(settled) |-> $past(sample));

  a_r6_mismatch_blocks: assert property (@(posedge clk) disable iff (rst)
    (sample && !clear && !settled && have_prev && (bit_in != prev_bit)) |=> !settled);
endmodule

// File: rtl/fc_timeout.sv
module fc_timeout #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      run     <= 1'b1;
      expired <= 1'b0;
    end else if (run) begin
      if (cnt == limit) begin
        expired <= 1'b1;
        run     <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r7_expire_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired && !start) |=> expired);

  a_r7_expire_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> $past(run));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flashctl_pkg::*;
#(
  parameter int T_SETUP       = 2,
  parameter int T_PULSE       = 6,
  parameter int T_HOLD        = 4,
  parameter int T_RDACC       = 10,
  parameter int CONFIRM_READS = 2,
  parameter int TMO_PROG      = 3000,
  parameter int TMO_ERASE     = 3750000,
  parameter int TMO_CHIP      = 7500000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [19:0] cmd_addr,
  input  logic [7:0]  cmd_data,
  output logic        done,
  output logic        done_err,
  output logic [19:0] fl_addr,
  output logic [7:0]  fl_dq_o,
  output logic        fl_dq_oe,
  input  logic [7:0]  fl_dq_i,
  output logic        fl_ce_n,
  output logic        fl_oe_n,
  output logic        fl_we_n
);
  localparam int TMO_A   = (TMO_PROG > TMO_ERASE) ? TMO_PROG : TMO_ERASE;
  localparam int TMO_MAX = (TMO_A > TMO_CHIP) ? TMO_A : TMO_CHIP;
  localparam int TMO_W   = $clog2(TMO_MAX + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_WAITW, ST_POLL, ST_WAITR, ST_CHECK} state_e;

  state_e            state;
  flash_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STEP_W-1:0] step;

  logic              bus_start, bus_rd, bus_done;
  logic [DATA_W-1:0] bus_rdata;
  bus_word_t         word;
  logic              first_poll, poll_sample, settled, expired;
  logic [TMO_W-1:0]  tmo_limit;

  assign word        = seq_word(op_q, step, addr_q, data_q);
  assign bus_start   = (state == ST_ISSUE) || (state == ST_POLL);
  assign bus_rd      = (state == ST_POLL);
  assign first_poll  = (state == ST_WAITW) && bus_done && (step == final_step(op_q));
  assign poll_sample = (state == ST_WAITR) && bus_done;

  always_comb begin
    case (op_q)
      OP_PROG: tmo_limit = TMO_W'(TMO_PROG);
      OP_CHIP: tmo_limit = TMO_W'(TMO_CHIP);
      default: tmo_limit = TMO_W'(TMO_ERASE);
    endcase
  end

  logic unused_status_bits;
  assign unused_status_bits = ^{bus_rdata[7], bus_rdata[5:0]};

  fc_bus_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_RDACC(T_RDACC)
  ) u_bus (
    .clk(clk), .rst(rst), .start(bus_start), .is_read(bus_rd),
    .addr_in(bus_rd ? addr_q : word.addr), .wdata(word.data), .dq_i(fl_dq_i),
    .done(bus_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  fc_toggle_poll #(.CONFIRM_READS(CONFIRM_READS)) u_poll (
    .clk(clk), .rst(rst), .clear(first_poll), .sample(poll_sample),
    .bit_in(bus_rdata[6]), .settled(settled)
  );

  fc_timeout #(.CNT_W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .start(first_poll), .limit(tmo_limit), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      step      <= '0;
      cmd_ready <= 1'b0;
      done      <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            op_q      <= flash_op_e'(cmd_op);
            addr_q    <= cmd_addr;
            data_q    <= cmd_data;
            step      <= '0;
            cmd_ready <= 1'b0;
            state     <= ST_ISSUE;
          end else begin
            cmd_ready <= 1'b1;
          end
        end
        ST_ISSUE: state <= ST_WAITW;
        ST_WAITW: begin
          if (bus_done) begin
            if (step == final_step(op_q)) state <= ST_POLL;
            else begin
              step  <= step + 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        ST_POLL: state <= ST_WAITR;
        ST_WAITR: if (bus_done) state <= ST_CHECK;
        default: begin
          if (settled || expired) begin
            done      <= 1'b1;
            done_err  <= !settled;
            cmd_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_POLL;
          end
        end
      endcase
    end
  end

  a_r8_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (fl_ce_n && !fl_dq_oe));

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
    done_err |-> done);
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int T_SETUP = 2, T_PULSE = 6, T_HOLD = 4, T_RDACC = 10;
  localparam int TMO_P = 2000, TMO_E = 4000, TMO_C = 6000;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [19:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic done, done_err;
  logic [19:0] fl_addr;
  logic [7:0] fl_dq_o, fl_dq_i;
  logic fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_RDACC(T_RDACC),
    .CONFIRM_READS(2), .TMO_PROG(TMO_P), .TMO_ERASE(TMO_E), .TMO_CHIP(TMO_C)) i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .done(done), .done_err(done_err),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

  int checks = 0, errors = 0;
  int cyc = 0, wd = 0;

  // Flash model: bit 6 flips after each read while busy reads remain.
  logic toggle_q = 1'b0;
  int busy_left = 0;
  assign fl_dq_i = {~toggle_q, toggle_q, 6'h15};

  // Bus monitor state
  logic [19:0] wr_addr [0:15];
  logic [7:0]  wr_data [0:15];
  int wr_n = 0, rd_n = 0, tim_bad = 0, rd_bad = 0, last_wr_cyc = 0;
  int pre_cnt = 0, low_cnt = 0, post_cnt = 0, rd_low = 0;
  bit in_post = 0;
  logic prev_we = 1, prev_oe = 1, prev_oe_en = 0;
  logic [19:0] prev_addr = '0, exp_rd_addr = '0;
  logic [7:0] prev_dq = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (fl_dq_oe && fl_we_n) begin
        if (prev_oe_en && prev_we && fl_addr == prev_addr && fl_dq_o == prev_dq) pre_cnt++;
        else pre_cnt = 1;
      end else if (!fl_dq_oe) pre_cnt = 0;
      if (!fl_we_n && prev_we) begin
        if (pre_cnt < T_SETUP) tim_bad++;
        low_cnt = 1;
      end else if (!fl_we_n) begin
        low_cnt++;
        if (fl_addr != prev_addr || fl_dq_o != prev_dq) tim_bad++;
      end
      if (fl_we_n && !prev_we) begin
        if (low_cnt != T_PULSE) tim_bad++;
        if (fl_addr != prev_addr || fl_dq_o != prev_dq) tim_bad++;
        if (wr_n < 16) begin wr_addr[wr_n] = fl_addr; wr_data[wr_n] = fl_dq_o; end
        wr_n++;
        last_wr_cyc = cyc;
        post_cnt = 1;
        in_post = 1;
      end else if (in_post) begin
        if (fl_dq_oe && fl_addr == prev_addr && fl_dq_o == prev_dq) post_cnt++;
        else begin
          if (post_cnt < T_HOLD) tim_bad++;
          in_post = 0;
        end
      end
      if (fl_dq_oe && (fl_ce_n != fl_we_n || !fl_oe_n)) tim_bad++;
      if (!fl_oe_n) begin
        rd_low = prev_oe ? 1 : rd_low + 1;
        if (!fl_we_n || fl_dq_oe || fl_ce_n || fl_addr != exp_rd_addr) rd_bad++;
      end
      if (fl_oe_n && !prev_oe) begin
        rd_n++;
        if (rd_low != T_RDACC) rd_bad++;
        if (busy_left > 0) begin toggle_q = ~toggle_q; busy_left--; end
      end
      prev_we = fl_we_n; prev_oe = fl_oe_n; prev_oe_en = fl_dq_oe;
      prev_addr = fl_addr; prev_dq = fl_dq_o;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] e_addr(input logic [1:0] op, input int i, input logic [19:0] a);
    case (i)
      0, 2: return 20'h00AAA;
      1, 4: return 20'h00555;
      3: return (op == 2'd0) ? a : 20'h00AAA;
      default: return (op == 2'd3) ? 20'h00AAA : a;
    endcase
  endfunction

  function automatic logic [7:0] e_data(input logic [1:0] op, input int i, input logic [7:0] d);
    case (i)
      0: return 8'hAA;
      1, 4: return 8'h55;
      2: return (op == 2'd0) ? 8'hA0 : 8'h80;
      3: return (op == 2'd0) ? d : 8'hAA;
      default: return (op == 2'd3) ? 8'h10 : ((op == 2'd1) ? 8'h30 : 8'h50);
    endcase
  endfunction

  function automatic int e_tmo(input logic [1:0] op);
    return (op == 2'd0) ? TMO_P : ((op == 2'd3) ? TMO_C : TMO_E);
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [19:0] a, input logic [7:0] d,
                         input int busy, input bit exp_err, input bit offer_busy);
    int n;
    int nwr;
    int done_cyc;
    int bad_ready;
    nwr = (op == 2'd0) ? 4 : 6;
    wr_n = 0; rd_n = 0; tim_bad = 0; rd_bad = 0;
    busy_left = busy; exp_rd_addr = a;
    n = 0;
    while (!cmd_ready && n < 100) begin @(negedge clk); n++; end
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
    if (offer_busy) begin
      bad_ready = 0;
      cmd_valid = 1; cmd_op = ~op; cmd_addr = ~a; cmd_data = ~d;
      for (int k = 0; k < 30; k++) begin
        if (cmd_ready) bad_ready++;
        @(negedge clk);
      end
      cmd_valid = 0;
      check(bad_ready == 0, "R8", "ready high while busy", bad_ready, 0);
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    done_cyc = cyc;
    check(done == 1'b1, "R6", "done seen", done, 1);
    check(done_err == exp_err, exp_err ? "R7" : "R6", "done_err", done_err, exp_err);
    check(cmd_ready == 1'b1, "R8", "ready at done", cmd_ready, 1);
    check(wr_n == nwr, (op == 2'd0) ? "R1" : "R2", "write count", wr_n, nwr);
    for (int i = 0; i < nwr && i < wr_n; i++) begin
      check(wr_addr[i] == e_addr(op, i, a), (op == 2'd0) ? "R1" : "R2", "write addr",
            wr_addr[i], e_addr(op, i, a));
      check(wr_data[i] == e_data(op, i, d), (op == 2'd0) ? "R1" : "R2", "write data",
            wr_data[i], e_data(op, i, d));
    end
    check(tim_bad == 0, "R3", "write timing violations", tim_bad, 0);
    check(rd_bad == 0, "R4", "read phase violations (R5 address)", rd_bad, 0);
    if (!exp_err)
      check(rd_n == busy + 4, "R6", "status read count", rd_n, busy + 4);
    else
      check((done_cyc - last_wr_cyc) >= e_tmo(op) && (done_cyc - last_wr_cyc) <= e_tmo(op) + 60,
            "R7", "timeout latency", done_cyc - last_wr_cyc, e_tmo(op));
    @(negedge clk);
    check(done == 1'b0 && done_err == 1'b0, "R9", "done single pulse", {done, done_err}, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n, "R10", "strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    check(!fl_dq_oe && !done, "R10", "bus drive/done in reset", {fl_dq_oe, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R10", "ready after reset", cmd_ready, 1);
    check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R10", "idle pins",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 14);

    run_cmd(2'd0, 20'h12345, 8'h3C, 0, 1'b0, 1'b0);  // R1 with a flash that is already idle
    run_cmd(2'd3, 20'hFFFFF, 8'h00, 3, 1'b0, 1'b0);  // R2 whole array, odd toggle count
    run_cmd(2'd1, 20'hAB000, 8'h00, 1, 1'b0, 1'b0);  // R2 R5 sector
    run_cmd(2'd2, 20'h70000, 8'h00, 2, 1'b0, 1'b0);  // R2 R5 block
    run_cmd(2'd0, 20'h00001, 8'hFF, 5, 1'b0, 1'b1);  // R8 offer while busy
    run_cmd(2'd0, 20'h0F0F0, 8'h81, 1000000, 1'b1, 1'b0);  // R7 byte-write limit
    run_cmd(2'd3, 20'h00000, 8'h00, 1000000, 1'b1, 1'b0);  // R7 whole-array limit
    run_cmd(2'd1, 20'h45000, 8'h00, 1000000, 1'b1, 1'b0);  // R7 erase limit
    for (int r = 0; r < 10; r++) begin
      run_cmd(2'($urandom_range(0, 3)), 20'($urandom), 8'($urandom),
              int'($urandom_range(0, 9)), 1'b0, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule